// File: doc/BRIEF.md
# Two-Word Multi-Cycle Stored-Program Processor

This block is a small multi-cycle processor that runs a program held in a separate instruction memory and works on values in a separate data memory. Each instruction takes two words. The first word holds the opcode and the register fields, and the second word is either a data-memory address or a branch target. The block reads the two words in two cycles into internal instruction registers, and the program counter moves forward by one word in each of those cycles. Execution follows.

Inside the block are an eight-entry, 16-bit register file and a four-flag condition register. ALU instructions combine two registers and write a third. Loads and stores move one register to or from data memory. Conditional branches test the flags left by the most recent ALU instruction. Both memory ports are read combinationally: the read data must belong to the address driven in that same cycle. Writes to data memory take effect at the clock edge while the write enable is high.

Top module: `cpu_two_word`

## Requirements
- R1: Every instruction is fetched as two words, at the program counter and then at the next address. `imem_addr_o` increments by one after each fetch cycle. The first word is the control word and the second is the operand word.
- R2: The control word is laid out as opcode [15:12], destination/source register d [11:9], operand register a [8:6] and operand register b [5:3]. Opcodes 1 to 5 (add, subtract, OR, XOR, AND) write d = a OP b, wrapping at 16 bits.
- R3: Opcode 6 (load) writes the data-memory word at the address in the operand word into register d.
- R4: Opcode 7 (store) writes register d to data memory at the operand-word address. `dmem_we_o` is high for exactly one cycle per store.
- R5: The flags are negative, zero, carry and overflow. Only ALU opcodes 1 to 5 change them. For a subtraction, carry means an unsigned borrow occurred.
- R6: Branch opcodes load the program counter with the operand word when their condition holds. The conditions are: 8 always, 9 zero, 10 not zero, 11 signed less (N xor V), 12 signed greater-or-equal, 13 signed greater (not Z and not (N xor V)), 14 carry set.
- R7: A branch whose condition fails continues with the instruction that directly follows it.
- R8: Opcodes 0 and 15 change no register and no flag, and execution continues with the next instruction.
- R9: While `rst_ni` is low, the program counter is zero, the write enable is low and every register is zero. After reset is released, fetch starts at address 0.
- R10: ALU, branch and no-op instructions take three cycles. Loads and stores take four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 8 | Instruction-memory word address (program counter) |
| imem_data_i | input | 16 | Instruction word at `imem_addr_o` |
| dmem_addr_o | output | 8 | Data-memory word address |
| dmem_wdata_o | output | 16 | Store data |
| dmem_we_o | output | 1 | Data-memory write enable |
| dmem_rdata_i | input | 16 | Data word at `dmem_addr_o` |

## Verification
The properties assume that the instruction port returns the word for the current address in the same cycle, and that a branch target fits the address width. The bench memories are combinational arrays indexed directly by the block's address outputs, so the first assumption holds by construction. Every program the bench writes uses targets inside its small instruction array. Register contents are never read from inside the block. They are brought out by store instructions and compared in data memory, and branch outcomes show up as which register was stored to a marker word.

// File: rtl/cpu2w_pkg.sv
package cpu2w_pkg;
  typedef enum logic [3:0] {
    OP_NOP = 4'h0, OP_ADD = 4'h1, OP_SUB = 4'h2, OP_OR  = 4'h3,
    OP_XOR = 4'h4, OP_AND = 4'h5, OP_LD  = 4'h6, OP_ST  = 4'h7,
    OP_BR  = 4'h8, OP_BEQ = 4'h9, OP_BNE = 4'hA, OP_BLT = 4'hB,
    OP_BGE = 4'hC, OP_BGT = 4'hD, OP_BCS = 4'hE, OP_UND = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {
    ST_FETCH0 = 2'd0, ST_FETCH1 = 2'd1, ST_EXEC = 2'd2, ST_MEM = 2'd3
  } state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic logic is_alu(opcode_e op);
    return (op >= OP_ADD) && (op <= OP_AND);
  endfunction

  function automatic logic is_mem(opcode_e op);
    return (op == OP_LD) || (op == OP_ST);
  endfunction
endpackage

// File: rtl/cpu2w_alu.sv
module cpu2w_alu
  import cpu2w_pkg::*;
#(
  parameter int DW = 16
) (
  input  opcode_e        op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  output logic [DW-1:0]  y_o,
  output flags_t         flags_o
);
  logic [DW:0] sum, diff;

  assign sum  = {1'b0, a_i} + {1'b0, b_i};
  assign diff = {1'b0, a_i} - {1'b0, b_i};

  always_comb begin
    y_o       = '0;
    flags_o.c = 1'b0;
    flags_o.v = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        y_o       = sum[DW-1:0];
        flags_o.c = sum[DW];
        flags_o.v = (a_i[DW-1] == b_i[DW-1]) && (sum[DW-1] != a_i[DW-1]);
      end
      OP_SUB: begin
        y_o       = diff[DW-1:0];
        flags_o.c = diff[DW];  // borrow
        flags_o.v = (a_i[DW-1] != b_i[DW-1]) && (diff[DW-1] != a_i[DW-1]);
      end
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_AND:  y_o = a_i & b_i;
      default: y_o = '0;
    endcase
    flags_o.n = y_o[DW-1];
    flags_o.z = (y_o == '0);
  end
endmodule

// File: rtl/cpu2w_regfile.sv
module cpu2w_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [RW-1:0]  wa_i,
  input  logic [DW-1:0]  wd_i,
  input  logic [RW-1:0]  ra_d_i,
  input  logic [RW-1:0]  ra_a_i,
  input  logic [RW-1:0]  ra_b_i,
  output logic [DW-1:0]  rd_d_o,
  output logic [DW-1:0]  rd_a_o,
  output logic [DW-1:0]  rd_b_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      regs_q[g] <= '0;
      else if (we_i && wa_i == RW'(g))  regs_q[g] <= wd_i;
    end
  end

  assign rd_d_o = regs_q[ra_d_i];
  assign rd_a_o = regs_q[ra_a_i];
  assign rd_b_o = regs_q[ra_b_i];
endmodule

// File: rtl/cpu2w_ctrl.sv
module cpu2w_ctrl
  import cpu2w_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  opcode_e op_i,
  input  flags_t  flags_i,
  output state_e  state_o,
  output logic    taken_o
);
  state_e state_q, state_d;
  logic   cond;
  logic   lt;

  assign lt = flags_i.n ^ flags_i.v;

  always_comb begin
    unique case (op_i)
      OP_BR:   cond = 1'b1;
      OP_BEQ:  cond = flags_i.z;
      OP_BNE:  cond = !flags_i.z;
      OP_BLT:  cond = lt;
      OP_BGE:  cond = !lt;
      OP_BGT:  cond = !flags_i.z && !lt;
      OP_BCS:  cond = flags_i.c;
      default: cond = 1'b0;
    endcase
  end

  assign taken_o = (state_q == ST_EXEC) && cond;

  always_comb begin
    unique case (state_q)
      ST_FETCH0: state_d = ST_FETCH1;
      ST_FETCH1: state_d = ST_EXEC;
      ST_EXEC:   state_d = is_mem(op_i) ? ST_MEM : ST_FETCH0;
      default:   state_d = ST_FETCH0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH0;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/cpu_two_word.sv
module cpu_two_word
  import cpu2w_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int NREG = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [AW-1:0]  imem_addr_o,
  input  logic [DW-1:0]  imem_data_i,
  output logic [AW-1:0]  dmem_addr_o,
  output logic [DW-1:0]  dmem_wdata_o,
  output logic           dmem_we_o,
  input  logic [DW-1:0]  dmem_rdata_i
);
  localparam int RW = $clog2(NREG);

  logic [AW-1:0] pc_q;
  logic [DW-1:0] i0_q, i1_q;
  flags_t        flags_q, alu_flags;
  state_e        state;
  logic          taken;
  opcode_e       op;
  logic [RW-1:0] fd, fa, fb;
  logic [DW-1:0] rd_d, rd_a, rd_b, alu_y, wd;
  logic          rf_we;

  assign op = opcode_e'(i0_q[15:12]);
  assign fd = i0_q[9+:RW];
  assign fa = i0_q[6+:RW];
  assign fb = i0_q[3+:RW];

  cpu2w_ctrl i_ctrl (
    .clk_i, .rst_ni, .op_i(op), .flags_i(flags_q),
    .state_o(state), .taken_o(taken)
  );

  cpu2w_alu #(.DW(DW)) i_alu (
    .op_i(op), .a_i(rd_a), .b_i(rd_b), .y_o(alu_y), .flags_o(alu_flags)
  );

  assign rf_we = (state == ST_EXEC && is_alu(op)) || (state == ST_MEM && op == OP_LD);
  assign wd    = (state == ST_MEM) ? dmem_rdata_i : alu_y;

  cpu2w_regfile #(.DW(DW), .NREG(NREG)) i_rf (
    .clk_i, .rst_ni, .we_i(rf_we), .wa_i(fd), .wd_i(wd),
    .ra_d_i(fd), .ra_a_i(fa), .ra_b_i(fb),
    .rd_d_o(rd_d), .rd_a_o(rd_a), .rd_b_o(rd_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      i0_q    <= '0;
      i1_q    <= '0;
      flags_q <= '0;
    end else begin
      unique case (state)
        ST_FETCH0: begin
          i0_q <= imem_data_i;
          pc_q <= pc_q + 1'b1;
        end
        ST_FETCH1: begin
          i1_q <= imem_data_i;
          pc_q <= pc_q + 1'b1;
        end
        ST_EXEC: begin
          if (taken)       pc_q    <= i1_q[AW-1:0];
          if (is_alu(op))  flags_q <= alu_flags;
        end
        default: ;
      endcase
    end
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = i1_q[AW-1:0];
  assign dmem_wdata_o = rd_d;
  assign dmem_we_o    = (state == ST_MEM) && (op == OP_ST);
endmodule

// File: rtl/cpu2w_chk.sv
module cpu2w_chk
  import cpu2w_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input state_e         state,
  input logic           taken,
  input logic [DW-1:0]  i0_q,
  input logic [DW-1:0]  i1_q,
  input flags_t         flags_q,
  input logic [AW-1:0]  imem_addr_o,
  input logic           dmem_we_o
);
  opcode_e op;
  assign op = opcode_e'(i0_q[15:12]);

  p_fetch_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FETCH0 || state == ST_FETCH1) |=> imem_addr_o == $past(imem_addr_o) + 1'b1);

  p_we_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |=> !dmem_we_o);

  p_flags_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state == ST_EXEC && is_alu(op)) |=> $stable(flags_q));

  p_branch_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && taken) |=> imem_addr_o == $past(i1_q[AW-1:0]));

  p_fall_through_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && !taken) |=> $stable(imem_addr_o));

  p_nop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && (op == OP_NOP || op == OP_UND)) |=> state == ST_FETCH0);

  p_mem_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_MEM |=> state == ST_FETCH0);
endmodule

bind cpu_two_word cpu2w_chk #(.DW(DW), .AW(AW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state(state), .taken(taken),
  .i0_q(i0_q), .i1_q(i1_q), .flags_q(flags_q),
  .imem_addr_o(imem_addr_o), .dmem_we_o(dmem_we_o)
);

// File: tb/test_cpu_two_word.sv
module test_cpu_two_word;
  localparam time TCLK = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr, dmem_addr;
  logic [15:0] imem_data, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [15:0] imem [32];
  logic [15:0] dmem [16];
  int          n_chk = 0, n_fail = 0, we_cnt = 0;
  bit          done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  cpu_two_word i_cpu_two_word (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata),
    .dmem_we_o(dmem_we), .dmem_rdata_i(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[4:0]];
  assign dmem_rdata = dmem[dmem_addr[3:0]];

  always @(posedge clk) if (dmem_we) begin
    dmem[dmem_addr[3:0]] <= dmem_wdata;
    we_cnt <= we_cnt + 1;
  end

  // {opcode, x, y, expected}
  localparam logic [63:0] VEC [8] = '{
    {16'h1, 16'h0003, 16'h0004, 16'h0007},
    {16'h1, 16'hFFFF, 16'h0001, 16'h0000},
    {16'h2, 16'h0005, 16'h0007, 16'hFFFE},
    {16'h2, 16'h8000, 16'h0001, 16'h7FFF},
    {16'h3, 16'h0F00, 16'h00F0, 16'h0FF0},
    {16'h4, 16'hAAAA, 16'hFFFF, 16'h5555},
    {16'h5, 16'h1234, 16'h0FF0, 16'h0230},
    {16'h1, 16'h7FFF, 16'h0001, 16'h8000}
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic clear_mem(input logic [15:0] x, input logic [15:0] y);
    for (int i = 0; i < 32; i++) imem[i] = 16'h0000;
    for (int i = 0; i < 16; i++) dmem[i] = 16'h0000;
    dmem[0] = x; dmem[1] = y; dmem[2] = 16'hDEAD; dmem[3] = 16'hBEEF;
  endtask

  // LD r1,[0]; LD r2,[1]; alu r3,r1,r2; ST r3,[2]; BR self
  task automatic load_alu_prog(input logic [15:0] alu_w, input logic [15:0] x, input logic [15:0] y);
    clear_mem(x, y);
    imem[0] = 16'h6200; imem[1] = 16'd0;
    imem[2] = 16'h6400; imem[3] = 16'd1;
    imem[4] = alu_w;    imem[5] = 16'd0;
    imem[6] = 16'h7600; imem[7] = 16'd2;
    imem[8] = 16'h8000; imem[9] = 16'd8;
  endtask

  // marker [3] = x when taken, 0 when not taken
  task automatic load_br_prog(input logic [3:0] cc, input logic [3:0] aop,
                              input logic [15:0] x, input logic [15:0] y);
    clear_mem(x, y);
    imem[0]  = 16'h6200;        imem[1]  = 16'd0;
    imem[2]  = 16'h6400;        imem[3]  = 16'd1;
    imem[4]  = {aop, 12'h650};  imem[5]  = 16'd0;
    imem[6]  = 16'h6800;        imem[7]  = 16'd0;  // load between ALU op and branch
    imem[8]  = {cc, 12'h000};   imem[9]  = 16'd14;
    imem[10] = 16'h7000;        imem[11] = 16'd3;
    imem[12] = 16'h8000;        imem[13] = 16'd16;
    imem[14] = 16'h7800;        imem[15] = 16'd3;
    imem[16] = 16'h8000;        imem[17] = 16'd16;
  endtask

  task automatic br_case(input string req, input logic [3:0] cc, input logic [3:0] aop,
                         input logic [15:0] x, input logic [15:0] y, input bit tk);
    load_br_prog(cc, aop, x, y);
    do_reset();
    repeat (60) @(negedge clk);
    chk(dmem[3] == (tk ? x : 16'h0000), req, dmem[3], tk ? x : 16'h0000);
  endtask

  initial begin
    clear_mem(16'h0, 16'h0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R9: reset state
    chk(imem_addr == 8'h00, "R9 pc in reset", {8'h0, imem_addr}, 16'h0);
    chk(dmem_we == 1'b0, "R9 we in reset", {15'h0, dmem_we}, 16'h0);

    // R1 R10: fetch stepping and instruction lengths
    load_alu_prog(16'h1650, 16'h1, 16'h2);
    do_reset();
    @(negedge clk);
    chk(imem_addr == 8'd1, "R1 first fetch step", {8'h0, imem_addr}, 16'd1);
    repeat (3) @(negedge clk);
    chk(imem_addr == 8'd2, "R10 load takes four cycles", {8'h0, imem_addr}, 16'd2);
    repeat (7) @(negedge clk);
    chk(imem_addr == 8'd6, "R10 alu takes three cycles", {8'h0, imem_addr}, 16'd6);

    // R2 R3 R4: table of ALU vectors
    for (int v = 0; v < 8; v++) begin
      load_alu_prog({VEC[v][51:48], 12'h650}, VEC[v][47:32], VEC[v][31:16]);
      we_cnt = 0;
      do_reset();
      repeat (40) @(negedge clk);
      chk(dmem[2] == VEC[v][15:0], "R2 R3 alu vector", dmem[2], VEC[v][15:0]);
      if (v == 0) chk(we_cnt == 1, "R4 single write pulse", 16'(we_cnt), 16'd1);
    end

    // R8: undefined and zero opcodes leave r3 at its reset value
    load_alu_prog(16'hF650, 16'h0003, 16'h0004);
    do_reset();
    repeat (40) @(negedge clk);
    chk(dmem[2] == 16'h0000, "R8 undefined opcode", dmem[2], 16'h0000);
    load_alu_prog(16'h0650, 16'h0003, 16'h0004);
    do_reset();
    repeat (40) @(negedge clk);
    chk(dmem[2] == 16'h0000, "R8 zero opcode", dmem[2], 16'h0000);

    // R5 R6 R7: branches (flags must survive the intervening load)
    br_case("R6 R5 beq equal",        4'h9, 4'h2, 16'h0005, 16'h0005, 1'b1);
    br_case("R7 bne equal",           4'hA, 4'h2, 16'h0005, 16'h0005, 1'b0);
    br_case("R6 bne differ",          4'hA, 4'h2, 16'h0006, 16'h0005, 1'b1);
    br_case("R6 blt less",            4'hB, 4'h2, 16'h0003, 16'h0005, 1'b1);
    br_case("R7 bge less",            4'hC, 4'h2, 16'h0003, 16'h0005, 1'b0);
    br_case("R6 R5 blt overflow",     4'hB, 4'h2, 16'h8000, 16'h0001, 1'b1);
    br_case("R6 bgt greater",         4'hD, 4'h2, 16'h0007, 16'h0005, 1'b1);
    br_case("R7 bgt equal",           4'hD, 4'h2, 16'h0005, 16'h0005, 1'b0);
    br_case("R5 R6 bcs add carry",    4'hE, 4'h1, 16'hFFFF, 16'h0001, 1'b1);
    br_case("R5 R7 bcs no borrow",    4'hE, 4'h2, 16'h0005, 16'h0003, 1'b0);
    br_case("R5 R6 bcs borrow",       4'hE, 4'h2, 16'h0003, 16'h0005, 1'b1);
    br_case("R6 br always",           4'h8, 4'h2, 16'h0005, 16'h0003, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule